// File: doc/BRIEF.md
# Access-Interval Expiry Replacement Controller

This block makes the replacement decision for one set of a highly associative cache. Each way keeps a small saturating event counter. The counter counts the accesses made to this set since that way's line was last touched. Each way also keeps two learned limits: the longest access interval seen in the current generation of the line, and a limit loaded at fill time from an outside predictor. That second limit is the longest interval learned in the prior generation.

A line whose counter has run past its prior-generation limit is treated as dead. It is marked expired, provided its confidence flag is set. On a miss, an expired line is evicted ahead of the least recently used line. Lines that will not be reused therefore leave early, and lines with long but regular reuse stay longer.

The cache front end sends one strobe per access to the set, with a hit flag and the hit way. One cycle after a miss, the block returns the chosen victim way. With it, it returns the victim's two limits, so the predictor can store them. The front end then fills the refilled line. The fill carries the predicted limit and the value learned for that line one generation earlier.

Top module: `expiry_repl_ctrl`

## Requirements
- R1: Every accepted access (acc_valid high, fill_valid low) adds one to the event counter of every way, including the accessed way. Each counter saturates at 15 and never wraps.
- R2: On an accepted hit, the hit way's incremented counter value is one completed interval. The way's current-generation maximum becomes the larger of itself and that value, and the way's counter is cleared to 0.
- R3: A way is expired when its confidence flag is 1 and its counter is strictly greater than its prior-generation limit. The counter used is the value after the current access's increment. A way with a clear confidence flag is never expired.
- R4: On an accepted miss, if any way is expired, the victim is the lowest-numbered expired way, and victim_expired is 1.
- R5: On an accepted miss with no expired way, the victim is the least recently used way, and victim_expired is 0. Hits and fills make the touched way most recently used. After reset the recency order, from least to most recent, is way 0, way 1, … way WAYS-1.
- R6: victim_valid is 1 in exactly the cycle after an accepted miss, and 0 otherwise. It comes with victim_way, victim_expired, and the victim's current-generation maximum (wb_cur_max) and prior-generation limit (wb_prior_max).
- R7: A fill clears the filled way's counter and current-generation maximum to 0 and loads fill_limit as its prior-generation limit. It sets the confidence flag only when fill_limit equals fill_hist. The filled way becomes most recently used.
- R8: When fill_valid and acc_valid are high in the same cycle, the access is dropped. No counter moves except through the fill, the recency order changes only through the fill, and no victim is reported.
- R9: After synchronous reset, every counter, limit and confidence flag is 0 and victim_valid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | One access to this set this cycle |
| acc_hit | input | 1 | The access hit |
| acc_way | input | $clog2(WAYS) | Way that hit |
| fill_valid | input | 1 | Refill of one way this cycle |
| fill_way | input | $clog2(WAYS) | Way being refilled |
| fill_limit | input | CNT_W | Predicted prior-generation limit for the new line |
| fill_hist | input | CNT_W | Limit learned for the new line one generation earlier |
| victim_valid | output | 1 | Victim fields are valid (cycle after a miss) |
| victim_way | output | $clog2(WAYS) | Chosen victim way |
| victim_expired | output | 1 | Victim was chosen by expiry rather than recency |
| wb_cur_max | output | CNT_W | Victim's current-generation maximum interval |
| wb_prior_max | output | CNT_W | Victim's prior-generation limit |

## Verification
A behavioural reference model, kept as integer arrays and a recency queue, predicts the outputs for every cycle. It is compared against the design on every clock.

The directed sequences cover five cases:
- A miss straight after reset, which separates the reset recency order from the expiry path.
- A set where only one way has confidence, which shows whether the confidence flag gates expiry.
- A counter that equals its limit and then exceeds it by one, which tests that the comparison is strict.
- A long run of misses without fills, which drives every counter into saturation.
- Fills that coincide with accesses, which shows that such accesses are dropped.

A long pseudo-random mix of hits, misses and fills with small limits then exercises expiry choices that overlap with recency choices.

// File: rtl/repl_pkg.sv
package repl_pkg;

    localparam int CNT_W   = 4;
    localparam int CNT_MAX = (1 << CNT_W) - 1;

    typedef logic [CNT_W-1:0] cnt_t;

    typedef struct packed {
        cnt_t cnt;
        cnt_t cur_max;
        cnt_t prior_max;
        logic conf;
    } way_meta_t;

    function automatic cnt_t sat_inc(input cnt_t v);
        return (v == cnt_t'(CNT_MAX)) ? v : v + cnt_t'(1);
    endfunction

    function automatic cnt_t max_of(input cnt_t a, input cnt_t b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/way_meta.sv
module way_meta
    import repl_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      acc_en,
    input  logic      hit_me,
    input  logic      fill_me,
    input  cnt_t      fill_limit,
    input  logic      fill_conf,
    output way_meta_t meta,
    output logic      exp_next
);
    way_meta_t meta_q;
    cnt_t      cnt_inc;

    assign cnt_inc  = sat_inc(meta_q.cnt);
    assign meta     = meta_q;
    assign exp_next = meta_q.conf && (cnt_inc > meta_q.prior_max);

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= '0;
        end else if (fill_me) begin
            meta_q.cnt       <= '0;
            meta_q.cur_max   <= '0;
            meta_q.prior_max <= fill_limit;
            meta_q.conf      <= fill_conf;
        end else if (acc_en) begin
            if (hit_me) begin
                meta_q.cur_max <= max_of(meta_q.cur_max, cnt_inc);
                meta_q.cnt     <= '0;
            end else begin
                meta_q.cnt <= cnt_inc;
            end
        end
    end

    // R1: a saturated counter stays saturated on a plain access
    assert_no_overflow_R1: assert property (@(posedge clk) disable iff (rst)
        (acc_en && !hit_me && !fill_me && meta_q.cnt == cnt_t'(CNT_MAX))
        |=> meta_q.cnt == cnt_t'(CNT_MAX));

    // R2: a hit closes the interval
    assert_hit_clears_R2: assert property (@(posedge clk) disable iff (rst)
        (acc_en && hit_me && !fill_me) |=> meta_q.cnt == '0);

    // R2: the current-generation maximum only grows inside a generation
    assert_cur_max_grows_R2: assert property (@(posedge clk) disable iff (rst)
        !fill_me |=> meta_q.cur_max >= $past(meta_q.cur_max));

    // R7: a fill starts a fresh generation
    assert_fill_resets_R7: assert property (@(posedge clk) disable iff (rst)
        fill_me |=> (meta_q.cnt == '0 && meta_q.cur_max == '0));

endmodule

// File: rtl/lru_age.sv
module lru_age #(
    parameter int WAYS  = 8,
    parameter int IDX_W = $clog2(WAYS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             touch_en,
    input  logic [IDX_W-1:0] touch_way,
    output logic [IDX_W-1:0] lru_way
);
    localparam logic [IDX_W-1:0] OLDEST = IDX_W'(WAYS - 1);

    logic [IDX_W-1:0] age_q [WAYS];
    logic [WAYS-1:0]  lru_vec;
    logic [WAYS-1:0]  mru_vec;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int w = 0; w < WAYS; w++) age_q[w] <= IDX_W'(WAYS - 1 - w);
        end else if (touch_en) begin
            for (int w = 0; w < WAYS; w++) begin
                if (IDX_W'(w) == touch_way)
                    age_q[w] <= '0;
                else if (age_q[w] < age_q[touch_way])
                    age_q[w] <= age_q[w] + IDX_W'(1);
            end
        end
    end

    genvar g;
    generate
        for (g = 0; g < WAYS; g++) begin : g_vec
            assign lru_vec[g] = (age_q[g] == OLDEST);
            assign mru_vec[g] = (age_q[g] == '0);
        end
    endgenerate

    always_comb begin
        lru_way = '0;
        for (int w = 0; w < WAYS; w++)
            if (lru_vec[w]) lru_way = IDX_W'(w);
    end

    // R5: the age values stay a permutation, so exactly one oldest and one newest way
    assert_one_lru_R5: assert property (@(posedge clk) disable iff (rst) $onehot(lru_vec));
    assert_one_mru_R5: assert property (@(posedge clk) disable iff (rst) $onehot(mru_vec));
    // R5: a touched way is newest afterwards
    assert_touch_newest_R5: assert property (@(posedge clk) disable iff (rst)
        touch_en |=> mru_vec[$past(touch_way)]);

endmodule

// File: rtl/victim_select.sv
module victim_select #(
    parameter int WAYS  = 8,
    parameter int IDX_W = $clog2(WAYS)
) (
    input  logic [WAYS-1:0]  exp_vec,
    input  logic [IDX_W-1:0] lru_way,
    output logic [IDX_W-1:0] pick,
    output logic             pick_exp
);
    always_comb begin
        pick     = lru_way;
        pick_exp = 1'b0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (exp_vec[w]) begin
                pick     = IDX_W'(w);
                pick_exp = 1'b1;
            end
        end
    end

    // R4: expiry path is taken exactly when some way is expired
    always_comb begin
        assert_exp_path_R4: assert (pick_exp == (|exp_vec));
    end

endmodule

// File: rtl/expiry_repl_ctrl.sv
module expiry_repl_ctrl
    import repl_pkg::*;
#(
    parameter int WAYS  = 8,
    parameter int IDX_W = $clog2(WAYS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             acc_valid,
    input  logic             acc_hit,
    input  logic [IDX_W-1:0] acc_way,
    input  logic             fill_valid,
    input  logic [IDX_W-1:0] fill_way,
    input  logic [CNT_W-1:0] fill_limit,
    input  logic [CNT_W-1:0] fill_hist,
    output logic             victim_valid,
    output logic [IDX_W-1:0] victim_way,
    output logic             victim_expired,
    output logic [CNT_W-1:0] wb_cur_max,
    output logic [CNT_W-1:0] wb_prior_max
);
    logic            acc_ok;
    logic            miss_ok;
    logic            fill_conf;
    way_meta_t       meta [WAYS];
    logic [WAYS-1:0] exp_vec;
    logic [IDX_W-1:0] lru_way;
    logic [IDX_W-1:0] pick;
    logic            pick_exp;
    logic            touch_en;
    logic [IDX_W-1:0] touch_way;

    assign acc_ok    = acc_valid && !fill_valid;
    assign miss_ok   = acc_ok && !acc_hit;
    assign fill_conf = (fill_limit == fill_hist);

    genvar g;
    generate
        for (g = 0; g < WAYS; g++) begin : g_way
            way_meta u_meta (
                .clk       (clk),
                .rst       (rst),
                .acc_en    (acc_ok),
                .hit_me    (acc_hit && acc_way == IDX_W'(g)),
                .fill_me   (fill_valid && fill_way == IDX_W'(g)),
                .fill_limit(fill_limit),
                .fill_conf (fill_conf),
                .meta      (meta[g]),
                .exp_next  (exp_vec[g])
            );
        end
    endgenerate

    assign touch_en  = fill_valid || (acc_ok && acc_hit);
    assign touch_way = fill_valid ? fill_way : acc_way;

    lru_age #(.WAYS(WAYS), .IDX_W(IDX_W)) u_lru (
        .clk      (clk),
        .rst      (rst),
        .touch_en (touch_en),
        .touch_way(touch_way),
        .lru_way  (lru_way)
    );

    victim_select #(.WAYS(WAYS), .IDX_W(IDX_W)) u_sel (
        .exp_vec (exp_vec),
        .lru_way (lru_way),
        .pick    (pick),
        .pick_exp(pick_exp)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            victim_valid   <= 1'b0;
            victim_way     <= '0;
            victim_expired <= 1'b0;
            wb_cur_max     <= '0;
            wb_prior_max   <= '0;
        end else begin
            victim_valid <= miss_ok;
            if (miss_ok) begin
                victim_way     <= pick;
                victim_expired <= pick_exp;
                wb_cur_max     <= meta[pick].cur_max;
                wb_prior_max   <= meta[pick].prior_max;
            end
        end
    end

    // R3: an expiry victim always carries confidence
    assert_exp_needs_conf_R3: assert property (@(posedge clk) disable iff (rst)
        (victim_valid && victim_expired) |-> meta[victim_way].conf);

    // R3: an expiry victim's counter is above its limit after the miss
    assert_exp_over_limit_R3: assert property (@(posedge clk) disable iff (rst)
        (victim_valid && victim_expired) |->
            meta[victim_way].cnt > meta[victim_way].prior_max);

    // R8: a cycle with a fill never yields a victim
    assert_fill_blocks_victim_R8: assert property (@(posedge clk) disable iff (rst)
        fill_valid |=> !victim_valid);

endmodule

// File: tb/test_expiry_repl_ctrl.sv
module test_expiry_repl_ctrl;
    localparam int WAYS = 8;
    localparam int IW   = 3;
    localparam int CMAX = 15;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic acc_valid = 0, acc_hit = 0, fill_valid = 0;
    logic [IW-1:0] acc_way = '0, fill_way = '0;
    logic [3:0] fill_limit = '0, fill_hist = '0;
    logic victim_valid, victim_expired;
    logic [IW-1:0] victim_way;
    logic [3:0] wb_cur_max, wb_prior_max;

    int checks = 0, fails = 0;
    bit done = 0;

    int m_cnt [WAYS];
    int m_cur [WAYS];
    int m_pri [WAYS];
    bit m_conf[WAYS];
    int order[$];              // front = most recent, back = least recent
    bit e_valid, e_exp;
    int e_way, e_cur, e_pri;

    always #2 clk = ~clk;      // 250 MHz

    expiry_repl_ctrl #(.WAYS(WAYS)) i_expiry_repl_ctrl (
        .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_hit(acc_hit),
        .acc_way(acc_way), .fill_valid(fill_valid), .fill_way(fill_way),
        .fill_limit(fill_limit), .fill_hist(fill_hist),
        .victim_valid(victim_valid), .victim_way(victim_way),
        .victim_expired(victim_expired), .wb_cur_max(wb_cur_max),
        .wb_prior_max(wb_prior_max));

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic touch(input int w);
        foreach (order[i]) if (order[i] == w) begin order.delete(i); break; end
        order.push_front(w);
    endtask

    task automatic model_reset();
        for (int w = 0; w < WAYS; w++) begin
            m_cnt[w] = 0; m_cur[w] = 0; m_pri[w] = 0; m_conf[w] = 0;
        end
        order.delete();
        for (int w = WAYS - 1; w >= 0; w--) order.push_back(w);  // way 0 at back
        e_valid = 0;
    endtask

    task automatic step(input bit av, input bit hit, input int aw,
                        input bit fv, input int fw, input int fl, input int fh);
        @(negedge clk);
        acc_valid = av; acc_hit = hit; acc_way = IW'(aw);
        fill_valid = fv; fill_way = IW'(fw);
        fill_limit = 4'(fl); fill_hist = 4'(fh);
        e_valid = 0;
        if (fv) begin                              // R7, R8
            m_cnt[fw] = 0; m_cur[fw] = 0; m_pri[fw] = fl; m_conf[fw] = (fl == fh);
            touch(fw);
        end else if (av) begin                     // R1
            for (int w = 0; w < WAYS; w++) begin
                int inc = (m_cnt[w] < CMAX) ? m_cnt[w] + 1 : CMAX;
                if (hit && w == aw) begin          // R2
                    if (inc > m_cur[w]) m_cur[w] = inc;
                    m_cnt[w] = 0;
                end else m_cnt[w] = inc;
            end
            if (hit) touch(aw);
            else begin
                e_valid = 1; e_exp = 0; e_way = order[$];
                for (int w = WAYS - 1; w >= 0; w--)   // R3, R4
                    if (m_conf[w] && m_cnt[w] > m_pri[w]) begin e_way = w; e_exp = 1; end
                e_cur = m_cur[e_way]; e_pri = m_pri[e_way];
            end
        end
        @(posedge clk);
        @(negedge clk);
        acc_valid = 0; fill_valid = 0;
        chk("R6", "victim_valid", victim_valid, e_valid);
        if (e_valid && victim_valid) begin
            chk(e_exp ? "R4" : "R5", "victim_way", victim_way, e_way);
            chk("R3", "victim_expired", victim_expired, e_exp);
            chk("R2", "wb_cur_max", wb_cur_max, e_cur);
            chk("R7", "wb_prior_max", wb_prior_max, e_pri);
        end
    endtask

    task automatic finish_run();
        if (done) return;
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog: actual hung expected finished");
        finish_run();
    end

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        // R9: reset state
        chk("R9", "victim_valid after reset", victim_valid, 0);
        chk("R9", "wb_prior_max after reset", wb_prior_max, 0);
        // R5: first miss picks way 0, no confidence anywhere
        step(1, 0, 0, 0, 0, 0, 0);
        chk("R9", "reset counters leave no expiry", victim_expired, 0);
        // R7: fill every way; only way 3 gets confidence (limit 1)
        for (int w = 0; w < WAYS; w++) step(0, 0, 0, 1, w, 1, (w == 3) ? 1 : 2);
        step(1, 0, 0, 0, 0, 0, 0);          // R3: count 1 equals limit, not expired -> LRU way 0
        step(1, 0, 0, 0, 0, 0, 0);          // R3/R4: count 2 exceeds limit -> way 3
        step(1, 1, 3, 0, 0, 0, 0);          // R2: hit way 3, interval 3
        step(1, 0, 0, 0, 0, 0, 0);          // way 3 reset, LRU again
        // R8: access dropped while a fill is in progress
        step(1, 0, 0, 1, 5, 6, 6);
        step(1, 1, 5, 1, 6, 0, 0);
        // R1: saturation with long miss run
        for (int i = 0; i < 20; i++) step(1, 0, 0, 0, 0, 0, 0);
        // R4: several expired ways, lowest one wins
        step(0, 0, 0, 1, 6, 0, 0);
        step(0, 0, 0, 1, 2, 0, 0);
        for (int i = 0; i < 3; i++) step(1, 0, 0, 0, 0, 0, 0);
        // mixed traffic
        for (int i = 0; i < 4000; i++) begin
            int op = $urandom_range(0, 99);
            int fl = $urandom_range(0, 4);
            int fh = ($urandom_range(0, 1) == 1) ? fl : $urandom_range(0, 4);
            if (op < 40)      step(1, 1, $urandom_range(0, WAYS - 1), 0, 0, 0, 0);
            else if (op < 65) step(1, 0, 0, 0, 0, 0, 0);
            else if (op < 85) step(0, 0, 0, 1, $urandom_range(0, WAYS - 1), fl, fh);
            else if (op < 90) step(1, $urandom_range(0, 1), $urandom_range(0, WAYS - 1),
                                   1, $urandom_range(0, WAYS - 1), fl, fh);
            else              step(0, 0, 0, 0, 0, 0, 0);
        end
        // R9: reset mid-run restores the initial order
        @(negedge clk); rst = 1;
        @(negedge clk); rst = 0;
        model_reset();
        chk("R9", "victim_valid after second reset", victim_valid, 0);
        step(1, 0, 0, 0, 0, 0, 0);
        finish_run();
    end
endmodule